// File: doc/BRIEF.md
# Write-Drain Mode Transition Unit

This block sits beside a memory controller's per-bank command queues and reacts when the controller switches into or out of write-drain mode. The policy that picks the mode lives elsewhere and drives one flag. When that flag differs from the mode the block holds, the block takes the new mode and walks the banks in order, one per cycle. In each bank it sorts work that has been partly issued. A lone column command of the type being phased out is flagged as a drain, so it may still finish. An ACTIVATE paired with a column command of that type is cancelled, and its request goes back to the waiting queue through a valid/ready port.

Two saturating counters hold the number of drain reads and drain writes still outstanding. The issue path reports each command it sends, and the counters drop when flagged commands go out in the matching mode. The block also times each write-mode period. On entry it reports the gap since the previous exit. On exit it reports the length of the period and how many reads and writes were issued during it.

The state machine has three states. IDLE waits for the flag to differ and takes the new mode (transition IDLE->SCAN). SCAN sorts the bank under the index and then either moves to the next bank (SCAN->SCAN), ends after the last bank (SCAN->IDLE), or opens a cancel handshake (SCAN->RETURN). RETURN holds the request valid until ready is seen, then goes on to the next bank (RETURN->SCAN) or ends (RETURN->IDLE).

Top module: `wdm_xition`

## Requirements
- R1: The block holds a mode that starts at 0 after reset. A new mode is accepted only in IDLE, on the first clock edge where `wmode_i` differs from `mode_o`, and `mode_o` takes the new value at that edge. `busy_o` is high from the moment the flag differs until the sweep has finished, and no issue may be presented while it is high.
- R2: Each bank has a 2-bit occupancy code at bits [2b+1:2b] of `bank_occ_i`: 0 means empty, 1 means one column command, 2 means an ACTIVATE followed by a column command, and 3 is illegal. `bank_col_wr_i[b]` is 1 when that column command is a WRITE. When the sweep reaches a bank with code 3, `err_o` pulses for that bank and nothing else happens to it.
- R3: On entry to write mode (0 to 1), the reads-to-drain count is cleared. Each bank holding a single READ is flagged with `mark_vld_o` and adds one to that count.
- R4: On entry to write mode, each bank holding ACTIVATE plus READ raises `rq_valid_o` with its index on `sweep_bank_o`. Both stay steady until `rq_ready_i` is seen.
- R5: When `bypass_en_i` is high and a bank's `bank_wq_empty_i` bit is 1, the cancel on entry described in R4 is skipped for that bank.
- R6: On exit from write mode (1 to 0), the writes-to-drain count is cleared. A single WRITE is flagged and adds one to that count. ACTIVATE plus WRITE is returned through the handshake whatever the bypass setting.
- R7: On entry, single WRITEs and ACTIVATE plus WRITE are left alone. On exit, single READs and ACTIVATE plus READ are left alone. Neither drain count changes for them.
- R8: `iss_cmd_i` uses 0 for ACTIVATE, 1 for PRECHARGE, 2 for READ and 3 for WRITE. An issued READ with `iss_drain_i` set lowers reads-to-drain only while in write mode. An issued WRITE with `iss_drain_i` set lowers writes-to-drain only while out of write mode. Neither count goes below zero, and non-drain issues leave both counts as they are.
- R9: The cycle after an entry, `gap_vld_o` pulses with the number of cycles between the last exit and this entry, but only if an exit has happened before. The cycle after an exit, `len_vld_o` pulses with the length of the period and with the READs and WRITEs issued during it. Those issue counts are then cleared.
- R10: Banks are visited in ascending order. Each takes one cycle, plus the handshake wait when it is returned, and each produces at most one flag, return or error event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wmode_i | input | 1 | Requested write-drain mode from the policy |
| bypass_en_i | input | 1 | Skip cancel on entry for banks with empty write queue |
| bank_occ_i | input | 2*NB | Per-bank occupancy code |
| bank_col_wr_i | input | NB | Per-bank column command is a WRITE |
| bank_wq_empty_i | input | NB | Per-bank write queue empty |
| iss_vld_i | input | 1 | A command is issued this cycle |
| iss_cmd_i | input | 2 | Issued command type |
| iss_drain_i | input | 1 | Issued command carries the drain flag |
| rq_ready_i | input | 1 | Request queue accepts the returned request |
| mode_o | output | 1 | Mode currently held |
| busy_o | output | 1 | Transition pending or sweep running; issues blocked |
| sweep_bank_o | output | IDX_W | Bank under the sweep index |
| mark_vld_o | output | 1 | Flag the column command of `sweep_bank_o` as a drain |
| rq_valid_o | output | 1 | Return the request of `sweep_bank_o` |
| err_o | output | 1 | Illegal queue content at `sweep_bank_o` |
| rd_drain_cnt_o | output | CNT_W | Reads still to drain |
| wr_drain_cnt_o | output | CNT_W | Writes still to drain |
| gap_vld_o | output | 1 | Gap statistic valid |
| gap_o | output | TS_W | Cycles from last exit to this entry |
| len_vld_o | output | 1 | Period statistics valid |
| len_o | output | TS_W | Length of the write-mode period in cycles |
| mode_rd_o | output | CNT_W | READs issued during the period |
| mode_wr_o | output | CNT_W | WRITEs issued during the period |

## Verification
The bench builds the block with four banks, so a single sweep can present an empty bank, a single column command, an ACTIVATE pair and the illegal code together. Because every bank holds different content, the ascending order and the one-event-per-bank rule can be checked event by event against a queue of expected events. A 3-bit drain counter and a 12-bit timestamp keep the counts small enough that a drain issued at zero shows the floor directly. Ready is held low for two cycles on every return, so the stall path and the hold of valid are exercised on each cancel.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_COL     = 2'd1,
        OCC_ACT_COL = 2'd2,
        OCC_BAD     = 2'd3
    } occ_e;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_PRE = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_RETURN = 2'd2
    } sweep_st_e;

endpackage

// File: rtl/wdm_sweep.sv
module wdm_sweep
    import wdm_pkg::*;
#(
    parameter int NB    = 4,
    parameter int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wmode_i,
    input  logic              bypass_en_i,
    input  logic [2*NB-1:0]   bank_occ_i,
    input  logic [NB-1:0]     bank_col_wr_i,
    input  logic [NB-1:0]     bank_wq_empty_i,
    input  logic              rq_ready_i,
    output logic              mode_o,
    output logic              accept_o,
    output logic              sweep_busy_o,
    output logic [IDX_W-1:0]  bank_o,
    output logic              mark_o,
    output logic              rq_valid_o,
    output logic              err_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

    sweep_st_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             mode_q, mode_d;

    occ_e occ;
    logic old_match, skip_cancel, cancel;

    // one process for the state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            mode_q  <= mode_d;
        end
    end

    // bank classification; after acceptance mode_q is the new mode,
    // so the retiring column type is WRITE when mode_q is 0
    always_comb begin
        occ         = occ_e'(bank_occ_i[idx_q*2 +: 2]);
        old_match   = (bank_col_wr_i[idx_q] != mode_q);
        skip_cancel = mode_q && bypass_en_i && bank_wq_empty_i[idx_q];
        cancel      = (occ == OCC_ACT_COL) && old_match && !skip_cancel;
    end

    // next state
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        mode_d   = mode_q;
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wmode_i != mode_q) begin
                    accept_o = 1'b1;
                    mode_d   = wmode_i;
                    idx_d    = '0;
                    state_d  = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (cancel) begin
                    state_d = ST_RETURN;
                end else if (idx_q == LAST_IDX) begin
                    state_d = ST_IDLE;
                end else begin
                    idx_d = idx_q + IDX_W'(1);
                end
            end
            ST_RETURN: begin
                if (rq_ready_i) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_d   = idx_q + IDX_W'(1);
                        state_d = ST_SCAN;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // one process for the outputs
    always_comb begin
        mode_o       = mode_q;
        bank_o       = idx_q;
        sweep_busy_o = (state_q != ST_IDLE);
        mark_o       = 1'b0;
        rq_valid_o   = 1'b0;
        err_o        = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SCAN: begin
                mark_o = (occ == OCC_COL) && old_match;
                err_o  = (occ == OCC_BAD);
            end
            ST_RETURN: rq_valid_o = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/wdm_drain_ctr.sv
module wdm_drain_ctr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !dec_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + W'(1);
        end else if (dec_i && !inc_i && cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wdm_stats.sv
module wdm_stats
    import wdm_pkg::*;
#(
    parameter int TS_W  = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             new_mode_i,
    input  logic             mode_i,
    input  logic             iss_vld_i,
    input  logic [1:0]       iss_cmd_i,
    output logic             gap_vld_o,
    output logic [TS_W-1:0]  gap_o,
    output logic             len_vld_o,
    output logic [TS_W-1:0]  len_o,
    output logic [CNT_W-1:0] mode_rd_o,
    output logic [CNT_W-1:0] mode_wr_o
);
    localparam logic [CNT_W-1:0] N_MAX = '1;

    logic [TS_W-1:0]  cyc_q, start_q, end_q;
    logic             seen_exit_q;
    logic [CNT_W-1:0] rds_q, wrs_q;
    logic             rd_iss, wr_iss;

    assign rd_iss = iss_vld_i && mode_i && (cmd_e'(iss_cmd_i) == CMD_RD);
    assign wr_iss = iss_vld_i && mode_i && (cmd_e'(iss_cmd_i) == CMD_WR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q       <= '0;
            start_q     <= '0;
            end_q       <= '0;
            seen_exit_q <= 1'b0;
            rds_q       <= '0;
            wrs_q       <= '0;
            gap_vld_o   <= 1'b0;
            gap_o       <= '0;
            len_vld_o   <= 1'b0;
            len_o       <= '0;
            mode_rd_o   <= '0;
            mode_wr_o   <= '0;
        end else begin
            cyc_q     <= cyc_q + TS_W'(1);
            gap_vld_o <= 1'b0;
            len_vld_o <= 1'b0;
            if (accept_i && new_mode_i) begin
                start_q   <= cyc_q;
                gap_vld_o <= seen_exit_q;
                gap_o     <= cyc_q - end_q;
            end else if (accept_i) begin
                end_q       <= cyc_q;
                seen_exit_q <= 1'b1;
                len_vld_o   <= 1'b1;
                len_o       <= cyc_q - start_q;
                mode_rd_o   <= rds_q;
                mode_wr_o   <= wrs_q;
                rds_q       <= '0;
                wrs_q       <= '0;
            end else begin
                if (rd_iss && rds_q != N_MAX) rds_q <= rds_q + CNT_W'(1);
                if (wr_iss && wrs_q != N_MAX) wrs_q <= wrs_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/wdm_xition.sv
module wdm_xition
    import wdm_pkg::*;
#(
    parameter  int NB    = 4,
    parameter  int CNT_W = 3,
    parameter  int TS_W  = 12,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wmode_i,
    input  logic             bypass_en_i,
    input  logic [2*NB-1:0]  bank_occ_i,
    input  logic [NB-1:0]    bank_col_wr_i,
    input  logic [NB-1:0]    bank_wq_empty_i,
    input  logic             iss_vld_i,
    input  logic [1:0]       iss_cmd_i,
    input  logic             iss_drain_i,
    input  logic             rq_ready_i,
    output logic             mode_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] sweep_bank_o,
    output logic             mark_vld_o,
    output logic             rq_valid_o,
    output logic             err_o,
    output logic [CNT_W-1:0] rd_drain_cnt_o,
    output logic [CNT_W-1:0] wr_drain_cnt_o,
    output logic             gap_vld_o,
    output logic [TS_W-1:0]  gap_o,
    output logic             len_vld_o,
    output logic [TS_W-1:0]  len_o,
    output logic [CNT_W-1:0] mode_rd_o,
    output logic [CNT_W-1:0] mode_wr_o
);
    logic accept, sweep_busy;
    logic drain_rd_iss, drain_wr_iss;

    wdm_sweep #(.NB(NB), .IDX_W(IDX_W)) u_sweep (
        .clk             (clk),
        .rst_n           (rst_n),
        .wmode_i         (wmode_i),
        .bypass_en_i     (bypass_en_i),
        .bank_occ_i      (bank_occ_i),
        .bank_col_wr_i   (bank_col_wr_i),
        .bank_wq_empty_i (bank_wq_empty_i),
        .rq_ready_i      (rq_ready_i),
        .mode_o          (mode_o),
        .accept_o        (accept),
        .sweep_busy_o    (sweep_busy),
        .bank_o          (sweep_bank_o),
        .mark_o          (mark_vld_o),
        .rq_valid_o      (rq_valid_o),
        .err_o           (err_o)
    );

    assign busy_o = sweep_busy || (wmode_i != mode_o);

    assign drain_rd_iss = iss_vld_i && iss_drain_i && mode_o
                          && (cmd_e'(iss_cmd_i) == CMD_RD);
    assign drain_wr_iss = iss_vld_i && iss_drain_i && !mode_o
                          && (cmd_e'(iss_cmd_i) == CMD_WR);

    wdm_drain_ctr #(.W(CNT_W)) u_rd_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept && wmode_i),
        .inc_i (mark_vld_o && mode_o),
        .dec_i (drain_rd_iss),
        .cnt_o (rd_drain_cnt_o)
    );

    wdm_drain_ctr #(.W(CNT_W)) u_wr_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept && !wmode_i),
        .inc_i (mark_vld_o && !mode_o),
        .dec_i (drain_wr_iss),
        .cnt_o (wr_drain_cnt_o)
    );

    wdm_stats #(.TS_W(TS_W), .CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .new_mode_i (wmode_i),
        .mode_i     (mode_o),
        .iss_vld_i  (iss_vld_i),
        .iss_cmd_i  (iss_cmd_i),
        .gap_vld_o  (gap_vld_o),
        .gap_o      (gap_o),
        .len_vld_o  (len_vld_o),
        .len_o      (len_o),
        .mode_rd_o  (mode_rd_o),
        .mode_wr_o  (mode_wr_o)
    );

endmodule

// File: rtl/wdm_xition_chk.sv
module wdm_xition_chk #(
    parameter  int NB    = 4,
    parameter  int CNT_W = 3,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rq_ready_i,
    input logic             mode_o,
    input logic             busy_o,
    input logic [IDX_W-1:0] sweep_bank_o,
    input logic             mark_vld_o,
    input logic             rq_valid_o,
    input logic             err_o,
    input logic [CNT_W-1:0] rd_drain_cnt_o,
    input logic [CNT_W-1:0] wr_drain_cnt_o,
    input logic             gap_vld_o,
    input logic             len_vld_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);
    localparam logic [CNT_W-1:0] CMAX     = '1;

    AST_EDGE_STARTS_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> busy_o); // R1

    AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (busy_o && !mark_vld_o && !rq_valid_o)); // R2

    AST_RD_MARK_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_vld_o && mode_o && rd_drain_cnt_o != CMAX)
        |=> (rd_drain_cnt_o == $past(rd_drain_cnt_o) + CNT_W'(1))); // R3

    AST_RQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid_o && !rq_ready_i) |=> (rq_valid_o && $stable(sweep_bank_o))); // R4

    AST_WR_MARK_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_vld_o && !mode_o && wr_drain_cnt_o != CMAX)
        |=> (wr_drain_cnt_o == $past(wr_drain_cnt_o) + CNT_W'(1))); // R6

    AST_RD_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drain_cnt_o == '0) |=> (rd_drain_cnt_o <= CNT_W'(1))); // R8

    AST_WR_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_drain_cnt_o == '0) |=> (wr_drain_cnt_o <= CNT_W'(1))); // R8

    AST_LEN_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        len_vld_o |-> (!mode_o && $past(mode_o))); // R9

    AST_GAP_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        gap_vld_o |-> (mode_o && !$past(mode_o))); // R9

    AST_MARK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_vld_o && sweep_bank_o != LAST_IDX)
        |=> (sweep_bank_o == $past(sweep_bank_o) + IDX_W'(1))); // R10

endmodule

bind wdm_xition wdm_xition_chk #(.NB(NB), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rq_ready_i     (rq_ready_i),
    .mode_o         (mode_o),
    .busy_o         (busy_o),
    .sweep_bank_o   (sweep_bank_o),
    .mark_vld_o     (mark_vld_o),
    .rq_valid_o     (rq_valid_o),
    .err_o          (err_o),
    .rd_drain_cnt_o (rd_drain_cnt_o),
    .wr_drain_cnt_o (wr_drain_cnt_o),
    .gap_vld_o      (gap_vld_o),
    .len_vld_o      (len_vld_o)
);

// File: tb/wdm_xition_tb.sv
module wdm_xition_tb;
    localparam int NB    = 4;
    localparam int CNT_W = 3;
    localparam int TS_W  = 12;
    localparam int IDX_W = 2;

    localparam int EV_MARK = 1;
    localparam int EV_RQ   = 2;
    localparam int EV_ERR  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wmode = 1'b0;
    logic             bypass = 1'b0;
    logic [2*NB-1:0]  occ = '0;
    logic [NB-1:0]    colwr = '0;
    logic [NB-1:0]    wqe = '0;
    logic             iss_vld = 1'b0;
    logic [1:0]       iss_cmd = 2'd0;
    logic             iss_drain = 1'b0;
    logic             rq_ready = 1'b0;
    logic             mode, busy, mark, rq_valid, err, gap_vld, len_vld;
    logic [IDX_W-1:0] sbank;
    logic [CNT_W-1:0] rd_cnt, wr_cnt, mrd, mwr;
    logic [TS_W-1:0]  gap, len;

    wdm_xition #(.NB(NB), .CNT_W(CNT_W), .TS_W(TS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wmode_i(wmode), .bypass_en_i(bypass),
        .bank_occ_i(occ), .bank_col_wr_i(colwr), .bank_wq_empty_i(wqe),
        .iss_vld_i(iss_vld), .iss_cmd_i(iss_cmd), .iss_drain_i(iss_drain),
        .rq_ready_i(rq_ready), .mode_o(mode), .busy_o(busy),
        .sweep_bank_o(sbank), .mark_vld_o(mark), .rq_valid_o(rq_valid),
        .err_o(err), .rd_drain_cnt_o(rd_cnt), .wr_drain_cnt_o(wr_cnt),
        .gap_vld_o(gap_vld), .gap_o(gap), .len_vld_o(len_vld), .len_o(len),
        .mode_rd_o(mrd), .mode_wr_o(mwr)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard of expected sweep events, {kind, bank}
    int exp_kind[$];
    int exp_bank[$];
    int gap_seen = 0, len_seen = 0;
    int last_gap = 0, last_len = 0, last_mrd = 0, last_mwr = 0;

    task automatic expect_ev(int k, int b);
        exp_kind.push_back(k);
        exp_bank.push_back(b);
    endtask

    task automatic take_ev(int k, int b);
        if (exp_kind.size() == 0) begin
            check("R10 unexpected sweep event kind", k, 0);
        end else begin
            int ek, eb;
            ek = exp_kind.pop_front();
            eb = exp_bank.pop_front();
            check("R10 sweep event kind (1 mark R3, 2 return R4, 3 error R2)", k, ek);
            check("R10 sweep event bank", b, eb);
        end
    endtask

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mark)                 take_ev(EV_MARK, int'(sbank));
            if (rq_valid && rq_ready) take_ev(EV_RQ, int'(sbank));
            if (err)                  take_ev(EV_ERR, int'(sbank));
            if (gap_vld) begin gap_seen++; last_gap = int'(gap); end
            if (len_vld) begin
                len_seen++; last_len = int'(len);
                last_mrd = int'(mrd); last_mwr = int'(mwr);
            end
        end
    end

    // request queue: ready after two cycles of valid
    int rdy_wait = 0;
    always @(posedge clk) begin
        #2;
        if (rq_ready) begin
            rq_ready = 1'b0;
            rdy_wait = 0;
        end else if (rq_valid) begin
            rdy_wait++;
            if (rdy_wait >= 2) rq_ready = 1'b1;
        end
    end

    task automatic set_bank(int b, int o, bit w, bit e);
        occ[b*2 +: 2] = 2'(o);
        colwr[b] = w;
        wqe[b] = e;
    endtask

    task automatic switch_mode(bit m, output int t);
        @(negedge clk);
        wmode = m;
        t = cyc;
        #1;
        check("R1 busy high once flag differs", int'(busy), 1);
        do @(negedge clk); while (busy);
        check("R10 all expected events seen", exp_kind.size(), 0);
        check("R1 mode taken", int'(mode), int'(m));
    endtask

    task automatic issue(int c, bit d);
        @(negedge clk);
        iss_vld = 1'b1; iss_cmd = 2'(c); iss_drain = d;
        @(negedge clk);
        iss_vld = 1'b0; iss_drain = 1'b0;
    endtask

    int t_en1, t_ex1, t_en2, t_ex2;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mode", int'(mode), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R3 reset read drain count", int'(rd_cnt), 0);
        check("R6 reset write drain count", int'(wr_cnt), 0);
        check("R4 reset return valid", int'(rq_valid), 0);

        // entry: b0 RD, b1 ACT+RD, b2 WR, b3 ACT+WR
        set_bank(0, 1, 0, 0); set_bank(1, 2, 0, 0);
        set_bank(2, 1, 1, 0); set_bank(3, 2, 1, 0);
        expect_ev(EV_MARK, 0); expect_ev(EV_RQ, 1);
        switch_mode(1'b1, t_en1);
        check("R3 one read to drain", int'(rd_cnt), 1);
        check("R7 write work untouched at entry", int'(wr_cnt), 0);
        check("R9 no gap before first exit", gap_seen, 0);

        issue(2, 1'b1);
        check("R8 drain read lowers count", int'(rd_cnt), 0);
        issue(2, 1'b1);
        check("R8 count floors at zero", int'(rd_cnt), 0);
        issue(3, 1'b0);
        issue(3, 1'b1);
        check("R8 drain write in write mode ignored", int'(wr_cnt), 0);

        // exit: b0 WR, b1 ACT+WR, b2 ACT+RD, b3 illegal
        set_bank(0, 1, 1, 0); set_bank(1, 2, 1, 0);
        set_bank(2, 2, 0, 0); set_bank(3, 3, 0, 0);
        expect_ev(EV_MARK, 0); expect_ev(EV_RQ, 1); expect_ev(EV_ERR, 3);
        switch_mode(1'b0, t_ex1);
        check("R6 one write to drain", int'(wr_cnt), 1);
        check("R7 read count untouched at exit", int'(rd_cnt), 0);
        check("R9 length pulse count", len_seen, 1);
        check("R9 period length", last_len, t_ex1 - t_en1);
        check("R9 reads in period", last_mrd, 2);
        check("R9 writes in period", last_mwr, 2);

        issue(3, 1'b0);
        check("R8 non-drain write ignored", int'(wr_cnt), 1);
        issue(3, 1'b1);
        check("R8 drain write lowers count", int'(wr_cnt), 0);

        // entry with bypass: b0 ACT+RD empty wq (skip), b1 ACT+RD, b2 RD, b3 empty
        bypass = 1'b1;
        set_bank(0, 2, 0, 1); set_bank(1, 2, 0, 0);
        set_bank(2, 1, 0, 0); set_bank(3, 0, 0, 0);
        expect_ev(EV_RQ, 1); expect_ev(EV_MARK, 2);
        switch_mode(1'b1, t_en2);
        check("R5 bypass entry read drain count", int'(rd_cnt), 1);
        check("R9 gap pulse count", gap_seen, 1);
        check("R9 gap length", last_gap, t_en2 - t_ex1);

        issue(2, 1'b1);
        issue(2, 1'b0);
        check("R8 drain read in write mode", int'(rd_cnt), 0);

        // exit with bypass: b0 ACT+WR empty wq (still returned), b1 RD, b2 WR, b3 ACT+RD
        set_bank(0, 2, 1, 1); set_bank(1, 1, 0, 1);
        set_bank(2, 1, 1, 1); set_bank(3, 2, 0, 1);
        expect_ev(EV_RQ, 0); expect_ev(EV_MARK, 2);
        switch_mode(1'b0, t_ex2);
        check("R6 exit write drain count", int'(wr_cnt), 1);
        check("R9 second period length", last_len, t_ex2 - t_en2);
        check("R9 second period reads", last_mrd, 2);
        check("R9 second period writes", last_mwr, 0);

        repeat (3) @(negedge clk);
        check("R10 no stray events", exp_kind.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule